// File: doc/BRIEF.md
# Slot Bit-Timing Regenerator

This block serves the slow bit rates of a strobed 8-bit serial slot. At those rates the serial bit clock cannot run the internal logic. The block therefore runs entirely on a fixed master clock. It recreates the eight bit cells of each slot from that clock and restarts its own timing whenever the frame strobe rises. The strobe is assumed asynchronous to the master clock, so it passes through a synchronizer first. Inside each regenerated cell the block launches one transmit bit at a fixed offset and samples one receive bit near the middle of the cell.

A 3-bit speed select sets the cell length and also decides whether this path runs at all. On the faster codes the surrounding logic uses the bit clock directly, and this block stays silent and ignores strobes.

Each direction adds one frame of latency. The transmit byte presented at one strobe is shifted out in the following frame. The byte received during a frame is handed over at the next strobe with a one-cycle valid pulse.

Top module: `slot_bit_regen`

## Requirements
- R1: While `rst` is high, and right after it is released: `dout_en`=0, `dout`=0, `rx_valid`=0 and `rx_byte`=0. The transmit holding byte resets to 0x00, so the first frame sends 0x00.
- R2: `async_active` is 1 for `speed_sel` = 3'b100 (32 master cycles per cell) and 3'b101 (16 master cycles per cell). It is 0 for every other code.
- R3: A strobe rise is detected on the third master-clock rising edge after the strobe goes high, through two synchronizer stages and one edge register. That edge is the frame start. `dout_en` stays 0 for 3 cycles after the frame start, then stays 1 for exactly 8 cells, then returns to 0.
- R4: During the window, `dout` carries the byte captured from `tx_byte` at the previous frame start, most significant bit first, one bit per cell. Outside the window, `dout` is 0.
- R5: Each cell lasts exactly the cell length selected by `speed_sel`. `dout` is stable from the first through the last cycle of a cell.
- R6: For bit n (n=0..7, MSB first), counting edges after the frame-start edge, `din` is sampled on edge 3 + cell/2 + n·cell. This is half a cell plus two cycles after the 3-cycle launch offset begins.
- R7: The byte assembled during a frame appears on `rx_byte`, together with a single-cycle `rx_valid`, in the cycle after the next frame start. `rx_byte` changes at no other time. There is no pulse after the first frame start following reset.
- R8: A strobe rise that arrives before 8 cells are complete restarts the timing at bit 0. The interrupted frame produces no `rx_valid`. The next frame transmits the byte captured at the interrupted strobe.
- R9: For any code other than 3'b100 and 3'b101, strobes are ignored. No window opens, no `rx_valid` is produced, and the transmit holding byte is not replaced.
- R10: If a frame start falls on the same edge that closes the eighth cell, the frame start takes precedence. The closing frame counts as incomplete and its byte is never released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (nominally 4096 kHz) |
| rst | input | 1 | Synchronous active-high reset |
| speed_sel | input | 3 | Speed select; 100 and 101 enable this path |
| strobe_in | input | 1 | Frame strobe, asynchronous, active high |
| din | input | 1 | Serial receive data |
| tx_byte | input | 8 | Byte to send in the following frame |
| dout | output | 1 | Serial transmit data |
| dout_en | output | 1 | Output-drive enable (high-impedance when 0) |
| rx_byte | output | 8 | Last complete received byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_byte` is updated |
| async_active | output | 1 | This path is selected by `speed_sel` |

## Verification
Two functions can land on the same clock edge: a new frame start, and the closing of the eighth cell of the previous frame. The bench provokes this by raising the strobe exactly three edges before the final cell closes. It does the same with the strobe delayed by one cycle. It expects no release in the coincident case and a normal release in the delayed case. A second overlap, realignment landing in the middle of a cell, is provoked by cutting a frame short after three and a half cells. It is judged by the absence of a receive pulse and by which byte the next frame transmits.

// File: rtl/slot_regen_pkg.sv
package slot_regen_pkg;

    typedef enum logic [1:0] {
        TM_IDLE,
        TM_LEAD,
        TM_CELLS
    } tm_state_e;

    // Per-cycle timing events produced by the slot timer
    typedef struct packed {
        logic start;    // frame start (strobe rise while enabled)
        logic window;   // inside the eight regenerated cells
        logic advance;  // last cycle of a cell
        logic sample;   // receive sample point
        logic finish;   // last cycle of the final cell
    } slot_evt_t;

    localparam logic [2:0] SEL_SLOW = 3'b100;
    localparam logic [2:0] SEL_FAST = 3'b101;

    function automatic logic sel_is_async(input logic [2:0] sel);
        return (sel == SEL_SLOW) || (sel == SEL_FAST);
    endfunction

    function automatic int unsigned sel_cell_len(input logic [2:0] sel,
                                                 input int unsigned slow,
                                                 input int unsigned fast);
        return (sel == SEL_FAST) ? fast : slow;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= strobe_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/slot_timer.sv
module slot_timer
    import slot_regen_pkg::*;
#(
    parameter int unsigned CELL_SLOW    = 32,
    parameter int unsigned CELL_FAST    = 16,
    parameter int unsigned LAUNCH       = 3,
    parameter int unsigned SAMPLE_EXTRA = 2,
    parameter int unsigned SLOT_BITS    = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       rise,
    input  logic [2:0] speed_sel,
    output slot_evt_t  evt
);
    localparam int unsigned CELL_MAX = max_u(CELL_SLOW, CELL_FAST);
    localparam int unsigned CNT_W    = $clog2(max_u(CELL_MAX, LAUNCH) + 1);
    localparam int unsigned BIT_W    = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;

    tm_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [BIT_W-1:0] bit_idx;
    logic [CNT_W-1:0] cell_last;
    logic [CNT_W-1:0] sample_at;
    logic [CNT_W-1:0] lead_last;
    logic             cell_end;
    logic             last_bit;

    always_comb begin
        cell_last = CNT_W'(sel_cell_len(speed_sel, CELL_SLOW, CELL_FAST) - 1);
        sample_at = CNT_W'(sel_cell_len(speed_sel, CELL_SLOW, CELL_FAST) / 2
                           + SAMPLE_EXTRA - LAUNCH);
        lead_last = CNT_W'(LAUNCH - 1);
        cell_end  = (state == TM_CELLS) && (cnt == cell_last);
        last_bit  = (bit_idx == BIT_W'(SLOT_BITS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TM_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
        end else if (!enable) begin
            state   <= TM_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
        end else if (rise) begin
            // realign: strobe wins over anything in flight
            state   <= TM_LEAD;
            cnt     <= '0;
            bit_idx <= '0;
        end else begin
            unique case (state)
                TM_LEAD: begin
                    if (cnt == lead_last) begin
                        state   <= TM_CELLS;
                        cnt     <= '0;
                        bit_idx <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TM_CELLS: begin
                    if (cell_end) begin
                        cnt <= '0;
                        if (last_bit) state <= TM_IDLE;
                        else          bit_idx <= bit_idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    cnt     <= '0;
                    bit_idx <= '0;
                end
            endcase
        end
    end

    always_comb begin
        evt.start   = enable & rise;
        evt.window  = (state == TM_CELLS);
        evt.advance = cell_end & enable & ~rise;
        evt.sample  = (state == TM_CELLS) && (cnt == sample_at) && enable && !rise;
        evt.finish  = cell_end & last_bit & enable & ~rise;
    end
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
    import slot_regen_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  slot_evt_t    evt,
    input  logic [W-1:0] tx_byte,
    output logic         dout,
    output logic         dout_en
);
    logic [W-1:0] hold_q;
    logic [W-1:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            shift_q <= '0;
        end else if (evt.start) begin
            shift_q <= hold_q;    // byte captured one frame earlier
            hold_q  <= tx_byte;
        end else if (evt.advance) begin
            shift_q <= {shift_q[W-2:0], 1'b0};
        end
    end

    assign dout_en = evt.window;
    assign dout    = evt.window ? shift_q[W-1] : 1'b0;
endmodule

// File: rtl/rx_deserializer.sv
module rx_deserializer
    import slot_regen_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  slot_evt_t    evt,
    input  logic         din,
    output logic [W-1:0] rx_byte,
    output logic         rx_valid
);
    logic [W-1:0] shift_q;
    logic         done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q  <= '0;
            done_q   <= 1'b0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= evt.start & done_q;
            if (evt.start && done_q) rx_byte <= shift_q;
            if (evt.start)       done_q <= 1'b0;
            else if (evt.finish) done_q <= 1'b1;
            if (evt.sample) shift_q <= {shift_q[W-2:0], din};
        end
    end
endmodule

// File: rtl/slot_bit_regen.sv
module slot_bit_regen
    import slot_regen_pkg::*;
#(
    parameter int unsigned CELL_SLOW    = 32,
    parameter int unsigned CELL_FAST    = 16,
    parameter int unsigned LAUNCH       = 3,
    parameter int unsigned SAMPLE_EXTRA = 2,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] speed_sel,
    input  logic       strobe_in,
    input  logic       din,
    input  logic [7:0] tx_byte,
    output logic       dout,
    output logic       dout_en,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       async_active
);
    localparam int unsigned SLOT_BITS = 8;

    logic      rise;
    slot_evt_t evt;

    assign async_active = sel_is_async(speed_sel);

    strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .strobe_in (strobe_in),
        .rise      (rise)
    );

    slot_timer #(
        .CELL_SLOW    (CELL_SLOW),
        .CELL_FAST    (CELL_FAST),
        .LAUNCH       (LAUNCH),
        .SAMPLE_EXTRA (SAMPLE_EXTRA),
        .SLOT_BITS    (SLOT_BITS)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .enable    (async_active),
        .rise      (rise),
        .speed_sel (speed_sel),
        .evt       (evt)
    );

    tx_serializer #(.W(SLOT_BITS)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .tx_byte (tx_byte),
        .dout    (dout),
        .dout_en (dout_en)
    );

    rx_deserializer #(.W(SLOT_BITS)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .din      (din),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );
endmodule

// File: rtl/slot_bit_regen_chk.sv
module slot_bit_regen_chk
    import slot_regen_pkg::*;
#(
    parameter int unsigned CELL_SLOW = 32,
    parameter int unsigned CELL_FAST = 16
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] speed_sel,
    input logic       strobe_in,
    input logic       din,
    input logic [7:0] tx_byte,
    input logic       dout,
    input logic       dout_en,
    input logic [7:0] rx_byte,
    input logic       rx_valid,
    input logic       async_active
);
    localparam int unsigned WIN_MAX = 8 * max_u(CELL_SLOW, CELL_FAST);
    localparam int unsigned RUN_W   = $clog2(WIN_MAX + 2);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !dout_en) run_q <= '0;
        else if (run_q != {RUN_W{1'b1}}) run_q <= run_q + 1'b1;
    end

    // R3: an output window never outlasts eight cells
    p_window_bound_r3: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> (run_q < RUN_W'(WIN_MAX)));

    // R4: nothing is driven outside the window
    p_quiet_outside_r4: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> !dout);

    // R7: the receive pulse lasts one cycle
    p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R7: the received byte only moves together with the pulse
    p_rx_stable_r7: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_byte));

    // R9: a non-async code closes any window by the next cycle
    p_sync_silent_r9: assert property (@(posedge clk) disable iff (rst)
        !async_active |=> !dout_en);

    // R9: a pulse can only follow a cycle in async mode
    p_valid_async_r9: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(async_active));
endmodule

bind slot_bit_regen slot_bit_regen_chk #(
    .CELL_SLOW (CELL_SLOW),
    .CELL_FAST (CELL_FAST)
) u_chk (.*);

// File: tb/tb_slot_bit_regen.sv
module tb_slot_bit_regen;
    localparam int C_SLOW = 32;
    localparam int C_FAST = 16;
    localparam int LAUNCH = 3;
    localparam int SEXTRA = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] speed_sel = 3'b100;
    logic       strobe_in = 1'b0;
    logic       din = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       dout, dout_en, rx_valid, async_active;
    logic [7:0] rx_byte;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] rxq[$];
    logic [7:0] hold_m = 8'h00;
    logic [7:0] prev_rx_m = 8'h00;
    bit         prev_done_m = 1'b0;

    always #5 clk = ~clk;

    slot_bit_regen dut (
        .clk(clk), .rst(rst), .speed_sel(speed_sel), .strobe_in(strobe_in),
        .din(din), .tx_byte(tx_byte), .dout(dout), .dout_en(dout_en),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .async_active(async_active)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: every release is matched against the scoreboard (R7)
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            if (rxq.size() == 0) begin
                check(1'b0, "R7", "unexpected rx_valid", rx_byte, 0);
            end else begin
                logic [7:0] e;
                e = rxq.pop_front();
                check(rx_byte == e, "R7", "released byte", rx_byte, e);
            end
        end
    end

    // one async frame; len = master cycles from frame start to next strobe raise
    task automatic async_frame(input logic [2:0] sel, input logic [7:0] txb,
                               input logic [7:0] rxb, input int len);
        int c;
        int s;
        logic [7:0] sent;
        c = (sel == 3'b101) ? C_FAST : C_SLOW;
        s = c / 2 + SEXTRA - LAUNCH;
        @(negedge clk);
        speed_sel = sel;
        tx_byte   = txb;
        strobe_in = 1'b1;
        repeat (3) @(posedge clk);           // frame-start edge
        sent   = hold_m;
        hold_m = txb;
        if (prev_done_m) rxq.push_back(prev_rx_m);
        prev_rx_m = rxb;
        for (int o = 0; o < len; o++) begin
            @(negedge clk);
            if (o == 1) strobe_in = 1'b0;
            if (o == 2) check(rxq.size() == 0, "R7", "pending release missing", rxq.size(), 0);
            if (o == LAUNCH - 1) check(!dout_en, "R3", "enable before launch", dout_en, 0);
            if (o >= LAUNCH && o < LAUNCH + 8 * c) begin
                int j;
                int k;
                j = (o - LAUNCH) / c;
                k = (o - LAUNCH) % c;
                if (k == 0 || k == c - 1)
                    check(dout_en && dout == sent[7-j], "R5", "cell edge bit", {dout_en, dout}, {1'b1, sent[7-j]});
                if (k == c / 2)
                    check(dout_en && dout == sent[7-j], "R4", "mid-cell bit", {dout_en, dout}, {1'b1, sent[7-j]});
                // correct value only around the sample edge (R6)
                din = (k >= s - 1 && k <= s + 1) ? rxb[7-j] : ~rxb[7-j];
            end else begin
                din = 1'b0;
            end
            if (o == LAUNCH + 8 * c)
                check(!dout_en && !dout, "R3", "window closed", {dout_en, dout}, 0);
        end
        @(posedge clk);
        prev_done_m = (len >= 8 * c + 1);   // R8, R10
    endtask

    // strobes in a direct-clock mode must be ignored (R9)
    task automatic sync_frame(input logic [2:0] sel, input logic [7:0] txb, input int len);
        bit seen;
        seen = 1'b0;
        @(negedge clk);
        speed_sel = sel;
        tx_byte   = txb;
        strobe_in = 1'b1;
        for (int o = 0; o < len; o++) begin
            @(negedge clk);
            if (o == 4) strobe_in = 1'b0;
            if (dout_en) seen = 1'b1;
        end
        check(!seen, "R9", "window opened in sync mode", seen, 0);
        check(!async_active, "R9", "async_active in sync mode", async_active, 0);
    endtask

    initial begin : watchdog
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(!dout_en && !dout, "R1", "output in reset", {dout_en, dout}, 0);
        check(!rx_valid && rx_byte == 8'h00, "R1", "receive in reset", {rx_valid, rx_byte}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!dout_en && !rx_valid && rx_byte == 8'h00, "R1", "after release", {dout_en, rx_valid, rx_byte}, 0);

        for (int code = 0; code < 8; code++) begin
            speed_sel = 3'(code);
            #1;
            check(async_active == (code == 4 || code == 5), "R2", "mode decode", async_active, (code == 4 || code == 5));
        end
        speed_sel = 3'b100;
        repeat (4) @(posedge clk);

        async_frame(3'b100, 8'hA5, 8'h3C, 8 * C_SLOW + 10);       // R1: sends reset byte 00
        async_frame(3'b100, 8'h5A, 8'hC3, 8 * C_SLOW + 10);
        async_frame(3'b101, 8'hF0, 8'h96, 8 * C_FAST + 10);
        async_frame(3'b101, 8'h0F, 8'h81, LAUNCH + 3 * C_FAST + 5); // R8 realign
        async_frame(3'b101, 8'h77, 8'h11, 8 * C_FAST + 10);
        async_frame(3'b101, 8'h12, 8'h34, 8 * C_FAST);              // R10 collision next
        async_frame(3'b101, 8'h9C, 8'h55, 8 * C_FAST + 1);          // R10 one cycle later
        async_frame(3'b101, 8'h66, 8'hA0, 8 * C_FAST + 10);
        sync_frame(3'b010, 8'hEE, 300);
        sync_frame(3'b000, 8'hDD, 300);
        async_frame(3'b100, 8'h00, 8'hFF, 8 * C_SLOW + 10);
        async_frame(3'b100, 8'h3C, 8'h00, 8 * C_SLOW + 10);
        async_frame(3'b100, 8'h00, 8'h5A, 8 * C_SLOW + 10);

        repeat (20) @(posedge clk);
        @(negedge clk);
        check(rxq.size() == 0, "R7", "unreleased expectations", rxq.size(), 0);
        check(!dout_en, "R3", "idle after last frame", dout_en, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule